// File: doc/BRIEF.md
# Streaming Ethernet Header Field Extractor

This block watches a byte-wide receive stream that carries one Ethernet frame at a time. The stream has a valid strobe and an end-of-frame marker, and the preamble and checksum are already removed. As the bytes arrive, the block picks out the header fields that a packet filter needs. At layer 2 these are both MAC addresses and the ethertype, with an optional 802.1Q tag recognised and skipped. At layer 3 it takes the protocol number and both addresses of an IPv4 header. At layer 4 it takes the ports of TCP and UDP and the flag byte of TCP.

Cycles with the valid strobe low stall the parse and may occur anywhere inside a frame. A busy flag is high while a frame is partly received. One cycle after the final byte, a single-cycle done pulse marks completion. The results are then presented together with a frame class and an error flag. The error flag is set for a frame that ended before its required header bytes, that carried an impossible IPv4 header length, or that was too long. The result outputs keep their values until the next done pulse, so a rule checker downstream can sample them at its leisure.

Top module: `hdr_field_extractor`

## Requirements
- R1: After reset, busy, done and hdr_error are low and every field output and frame_class are zero.
- R2: busy is high from the cycle after the first accepted byte of a frame (when that byte is not the last) until the cycle after its last byte. done is high for exactly the one cycle after the last byte is accepted, and busy is low in that cycle. Cycles with in_valid low neither advance nor end a frame.
- R3: dst_mac is bytes 0..5 and src_mac is bytes 6..11 of the frame. Byte 0 of the frame is the most significant byte of dst_mac, and likewise byte 6 for src_mac.
- R4: When bytes 12..13 hold 0x8100, vlan_tagged is 1, bytes 14..15 are skipped, eth_type is taken from bytes 16..17, and all later offsets move by 4. Otherwise eth_type is bytes 12..13 and vlan_tagged is 0.
- R5: frame_class encodes 0 = other ethertype, 1 = ARP (0x0806), 2 = IPv4 (0x0800) with any other protocol, 3 = TCP (protocol 6), 4 = UDP (protocol 17) and 5 = ICMP (protocol 1).
- R6: For IPv4, ip_proto is the byte at IP offset 9, ip_src is bytes 12..15 and ip_dst is bytes 16..19, most significant first. For any other ethertype, ip_proto, ip_src, ip_dst, the ports and tcp_flags are zero.
- R7: The layer-4 header starts at IP offset IHL×4, where IHL is the low nibble of the first IP byte. Option bytes in between are skipped.
- R8: For TCP and UDP, l4_src_port is layer-4 bytes 0..1 and l4_dst_port is bytes 2..3. For every other class, both ports are zero.
- R9: For TCP, tcp_flags is layer-4 byte 13. For every other class it is zero.
- R10: hdr_error is set when the frame has fewer bytes than required. An untagged frame needs 14 and a tagged frame needs 18. IPv4 also needs the whole IP header of at least 20 bytes. TCP additionally needs 14 layer-4 bytes and UDP needs 4.
- R11: hdr_error is set for an IPv4 frame whose IHL is below 5.
- R12: hdr_error is set for a frame longer than MAX_FRAME bytes (default 1522). A frame of exactly MAX_FRAME bytes is not flagged for length.
- R13: All result outputs hold their values after done until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| busy | output | 1 | Frame partly received |
| done | output | 1 | One-cycle completion pulse |
| hdr_error | output | 1 | Truncated, malformed or over-long frame |
| frame_class | output | 3 | Frame class code |
| vlan_tagged | output | 1 | 802.1Q tag seen |
| dst_mac | output | 48 | Destination MAC |
| src_mac | output | 48 | Source MAC |
| eth_type | output | 16 | Ethertype after any tag |
| ip_proto | output | 8 | IPv4 protocol number |
| ip_src | output | 32 | IPv4 source address |
| ip_dst | output | 32 | IPv4 destination address |
| l4_src_port | output | 16 | TCP/UDP source port |
| l4_dst_port | output | 16 | TCP/UDP destination port |
| tcp_flags | output | 8 | TCP flag byte |

## Verification
The hardest case to reach is a frame that ends one byte before or exactly at its required length. The required length is built from three things stacked on one another: the tag shift, the IHL option skip and the layer-4 kind. Directed frames therefore hit both sides of each threshold: a tagged stub, TCP at 14 and 13 layer-4 bytes, UDP with options at 4 and 3 bytes, and length at 1522 and 1523. Random frames then mix tags, IHL values of 3 to 8, classes, idle gaps and random cut points. Each of these is compared against a reference parse written in the bench.

// File: rtl/hfx_pkg.sv
package hfx_pkg;

    localparam logic [15:0] ETH_IPV4 = 16'h0800;
    localparam logic [15:0] ETH_ARP  = 16'h0806;
    localparam logic [15:0] ETH_VLAN = 16'h8100;

    localparam logic [7:0] PROTO_ICMP = 8'd1;
    localparam logic [7:0] PROTO_TCP  = 8'd6;
    localparam logic [7:0] PROTO_UDP  = 8'd17;

    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_ARP   = 3'd1,
        CLS_IPV4  = 3'd2,
        CLS_TCP   = 3'd3,
        CLS_UDP   = 3'd4,
        CLS_ICMP  = 3'd5
    } frame_cls_e;

    typedef struct packed {
        logic [47:0] dmac;
        logic [47:0] smac;
        logic [15:0] etype;
        logic        vlan;
        logic [7:0]  proto;
        logic [31:0] sip;
        logic [31:0] dip;
        logic [15:0] sport;
        logic [15:0] dport;
        logic [7:0]  flags;
    } hdr_t;

endpackage

// File: rtl/hfx_pos_ctr.sv
module hfx_pos_ctr #(
    parameter int unsigned POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic [POS_W-1:0] pos,
    output logic             busy
);
    localparam logic [POS_W-1:0] POS_TOP = '1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             busy;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (in_last) begin
                st_d.pos  = '0;
                st_d.busy = 1'b0;
            end else begin
                st_d.busy = 1'b1;
                if (st_q.pos != POS_TOP) st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos  = st_q.pos;
    assign busy = st_q.busy;

    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (pos == '0 && !busy));                 // R2
    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_last && pos != POS_TOP) |=> (pos == $past(pos) + POS_W'(1) && busy)); // R2
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pos) && $stable(busy));                  // R2

endmodule

// File: rtl/hfx_parse.sv
module hfx_parse
    import hfx_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1522,
    parameter int unsigned POS_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic [POS_W-1:0] pos,
    output hdr_t             res,
    output frame_cls_e       cls,
    output logic             err,
    output logic             done
);
    localparam int unsigned NW = POS_W + 1;
    localparam logic [NW-1:0] N_MAX  = NW'(MAX_FRAME);
    localparam logic [NW-1:0] N_PLN  = NW'(14);
    localparam logic [NW-1:0] N_TAG  = NW'(18);
    localparam logic [NW-1:0] N_IPH  = NW'(20);
    localparam logic [NW-1:0] N_TCPH = NW'(14);
    localparam logic [NW-1:0] N_UDPH = NW'(4);

    typedef struct packed {
        hdr_t       wk;
        logic [3:0] ihl;
        hdr_t       res;
        frame_cls_e cls;
        logic       err;
        logic       done;
    } st_t;

    st_t st_d, st_q;

    logic [POS_W-1:0] l3b_q, l4b_q, r3, r4;
    logic             ip_on, l4_on;
    hdr_t             w;
    logic [3:0]       ihl_w;
    logic [NW-1:0]    n_bytes, b2, l4e;
    logic             e_chk;
    frame_cls_e       c_nx;

    // Offsets seen by the byte now arriving, from registered header state.
    always_comb begin
        l3b_q = st_q.wk.vlan ? POS_W'(18) : POS_W'(14);
        l4b_q = l3b_q + POS_W'({st_q.ihl, 2'b00});
        r3    = pos - l3b_q;
        r4    = pos - l4b_q;
        ip_on = (st_q.wk.etype == ETH_IPV4) && (pos >= l3b_q);
        l4_on = ip_on && (st_q.ihl >= 4'd5) && (pos >= l4b_q);
    end

    // Field capture for the current byte.
    always_comb begin
        w     = st_q.wk;
        ihl_w = st_q.ihl;
        if (in_valid) begin
            if (pos < POS_W'(6))       w.dmac = {w.dmac[39:0], in_data};
            else if (pos < POS_W'(12)) w.smac = {w.smac[39:0], in_data};
            if (pos == POS_W'(12) || pos == POS_W'(13) ||
                (st_q.wk.vlan && (pos == POS_W'(16) || pos == POS_W'(17))))
                w.etype = {w.etype[7:0], in_data};
            if (pos == POS_W'(13) && {st_q.wk.etype[7:0], in_data} == ETH_VLAN)
                w.vlan = 1'b1;
            if (ip_on) begin
                if (r3 == POS_W'(0)) ihl_w = in_data[3:0];
                if (r3 == POS_W'(9)) w.proto = in_data;
                if (r3 >= POS_W'(12) && r3 < POS_W'(16)) w.sip = {w.sip[23:0], in_data};
                if (r3 >= POS_W'(16) && r3 < POS_W'(20)) w.dip = {w.dip[23:0], in_data};
            end
            if (l4_on && (st_q.wk.proto == PROTO_TCP || st_q.wk.proto == PROTO_UDP)) begin
                if (r4 < POS_W'(2))      w.sport = {w.sport[7:0], in_data};
                else if (r4 < POS_W'(4)) w.dport = {w.dport[7:0], in_data};
            end
            if (l4_on && st_q.wk.proto == PROTO_TCP && r4 == POS_W'(13))
                w.flags = in_data;
        end
    end

    // Completion judgement on the final byte, from the updated fields.
    always_comb begin
        n_bytes = {1'b0, pos} + NW'(1);
        b2      = w.vlan ? N_TAG : N_PLN;
        l4e     = b2 + NW'({ihl_w, 2'b00});
        e_chk   = 1'b0;
        if (n_bytes < b2) begin
            e_chk = 1'b1;
        end else if (w.etype == ETH_IPV4) begin
            if (n_bytes < b2 + N_IPH)                                  e_chk = 1'b1;
            else if (ihl_w < 4'd5)                                     e_chk = 1'b1;
            else if (n_bytes < l4e)                                    e_chk = 1'b1;
            else if (w.proto == PROTO_TCP && n_bytes < l4e + N_TCPH)   e_chk = 1'b1;
            else if (w.proto == PROTO_UDP && n_bytes < l4e + N_UDPH)   e_chk = 1'b1;
        end
        if (n_bytes > N_MAX) e_chk = 1'b1;

        c_nx = CLS_OTHER;
        if (w.etype == ETH_ARP) c_nx = CLS_ARP;
        else if (w.etype == ETH_IPV4) begin
            if (w.proto == PROTO_TCP)       c_nx = CLS_TCP;
            else if (w.proto == PROTO_UDP)  c_nx = CLS_UDP;
            else if (w.proto == PROTO_ICMP) c_nx = CLS_ICMP;
            else                            c_nx = CLS_IPV4;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.wk   = w;
        st_d.ihl  = ihl_w;
        st_d.done = 1'b0;
        if (in_valid && in_last) begin
            st_d.res  = w;
            st_d.cls  = c_nx;
            st_d.err  = e_chk;
            st_d.done = 1'b1;
            st_d.wk   = '0;
            st_d.ihl  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res  = st_q.res;
    assign cls  = st_q.cls;
    assign err  = st_q.err;
    assign done = st_q.done;

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_last));                          // R2
    AST_NONIP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cls == CLS_ARP || cls == CLS_OTHER)) |-> (res.sip == '0 && res.dip == '0 && res.proto == '0)); // R6
    AST_PORTS_TCP_UDP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls != CLS_TCP && cls != CLS_UDP) |-> (res.sport == '0 && res.dport == '0)); // R8
    AST_FLAGS_TCP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls != CLS_TCP) |-> (res.flags == '0));               // R9
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res) && $stable(err) && $stable(cls)));     // R13

endmodule

// File: rtl/hdr_field_extractor.sv
module hdr_field_extractor
    import hfx_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 1522
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        busy,
    output logic        done,
    output logic        hdr_error,
    output logic [2:0]  frame_class,
    output logic        vlan_tagged,
    output logic [47:0] dst_mac,
    output logic [47:0] src_mac,
    output logic [15:0] eth_type,
    output logic [7:0]  ip_proto,
    output logic [31:0] ip_src,
    output logic [31:0] ip_dst,
    output logic [15:0] l4_src_port,
    output logic [15:0] l4_dst_port,
    output logic [7:0]  tcp_flags
);
    localparam int unsigned POS_W = $clog2(MAX_FRAME + 2);

    logic [POS_W-1:0] pos;
    hdr_t             res;
    frame_cls_e       cls;

    hfx_pos_ctr #(.POS_W(POS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .pos      (pos),
        .busy     (busy)
    );

    hfx_parse #(.MAX_FRAME(MAX_FRAME), .POS_W(POS_W)) u_parse (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .pos      (pos),
        .res      (res),
        .cls      (cls),
        .err      (hdr_error),
        .done     (done)
    );

    assign frame_class = cls;
    assign vlan_tagged = res.vlan;
    assign dst_mac     = res.dmac;
    assign src_mac     = res.smac;
    assign eth_type    = res.etype;
    assign ip_proto    = res.proto;
    assign ip_src      = res.sip;
    assign ip_dst      = res.dip;
    assign l4_src_port = res.sport;
    assign l4_dst_port = res.dport;
    assign tcp_flags   = res.flags;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                               // R2
    AST_UNTAGGED_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hdr_error && !vlan_tagged) |-> (eth_type != ETH_VLAN)); // R4

endmodule

// File: tb/hdr_field_extractor_test.sv
module hdr_field_extractor_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF = 1522;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_last = 1'b0;
    logic busy, done, hdr_error, vlan_tagged;
    logic [2:0] frame_class;
    logic [47:0] dst_mac, src_mac;
    logic [15:0] eth_type, l4_src_port, l4_dst_port;
    logic [7:0] ip_proto, tcp_flags;
    logic [31:0] ip_src, ip_dst;

    hdr_field_extractor #(.MAX_FRAME(MAXF)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .busy(busy), .done(done), .hdr_error(hdr_error), .frame_class(frame_class),
        .vlan_tagged(vlan_tagged), .dst_mac(dst_mac), .src_mac(src_mac), .eth_type(eth_type),
        .ip_proto(ip_proto), .ip_src(ip_src), .ip_dst(ip_dst),
        .l4_src_port(l4_src_port), .l4_dst_port(l4_dst_port), .tcp_flags(tcp_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] fb [0:1599];
    int flen;

    logic        x_err, x_vl;
    logic [2:0]  x_cls;
    logic [47:0] x_dmac, x_smac;
    logic [15:0] x_et, x_sp, x_dp;
    logic [7:0]  x_pr, x_fl;
    logic [31:0] x_si, x_di;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] v);
        if (flen < 1600) fb[flen] = v;
        flen++;
    endtask

    // kind: 0 other ethertype, 1 ARP, 2 TCP, 3 UDP, 4 ICMP, 5 IPv4 other protocol
    task automatic build(input int kind, input bit vl, input int ihl, input int pay);
        int hb;
        flen = 0;
        repeat (12) put(8'($urandom));
        if (vl) begin put(8'h81); put(8'h00); put(8'($urandom)); put(8'($urandom)); end
        if (kind == 0) begin
            put(8'h90); put(8'($urandom));
        end else if (kind == 1) begin
            put(8'h08); put(8'h06); repeat (28) put(8'($urandom));
        end else begin
            put(8'h08); put(8'h00);
            hb = (ihl * 4 < 20) ? 20 : ihl * 4;
            put({4'h4, 4'(ihl)});
            repeat (8) put(8'($urandom));
            case (kind)
                2: put(8'd6);
                3: put(8'd17);
                4: put(8'd1);
                default: put(8'd47);
            endcase
            repeat (hb - 10) put(8'($urandom));
            if (kind == 2) repeat (20) put(8'($urandom));
            else           repeat (8)  put(8'($urandom));
        end
        repeat (pay) put(8'($urandom));
    endtask

    task automatic ref_model();
        int base, ihl, l4;
        x_err = 0; x_vl = 0; x_cls = 0; x_dmac = 0; x_smac = 0; x_et = 0;
        x_pr = 0; x_si = 0; x_di = 0; x_sp = 0; x_dp = 0; x_fl = 0;
        base = 14;
        if (flen >= 14 && fb[12] == 8'h81 && fb[13] == 8'h00) begin x_vl = 1; base = 18; end
        if (flen < base) x_err = 1;
        else begin
            for (int i = 0; i < 6; i++) x_dmac = {x_dmac[39:0], fb[i]};
            for (int i = 6; i < 12; i++) x_smac = {x_smac[39:0], fb[i]};
            x_et = {fb[base-2], fb[base-1]};
            if (x_et == 16'h0806) x_cls = 1;
            else if (x_et == 16'h0800) begin
                x_cls = 2;
                if (flen < base + 20) x_err = 1;
                else begin
                    ihl = int'(fb[base][3:0]);
                    x_pr = fb[base+9];
                    x_si = {fb[base+12], fb[base+13], fb[base+14], fb[base+15]};
                    x_di = {fb[base+16], fb[base+17], fb[base+18], fb[base+19]};
                    if (ihl < 5) x_err = 1;
                    else begin
                        l4 = base + ihl * 4;
                        if (x_pr == 8'd6) x_cls = 3;
                        else if (x_pr == 8'd17) x_cls = 4;
                        else if (x_pr == 8'd1) x_cls = 5;
                        if (flen < l4) x_err = 1;
                        else if (x_pr == 8'd6) begin
                            if (flen < l4 + 14) x_err = 1;
                            else begin
                                x_sp = {fb[l4], fb[l4+1]}; x_dp = {fb[l4+2], fb[l4+3]};
                                x_fl = fb[l4+13];
                            end
                        end else if (x_pr == 8'd17) begin
                            if (flen < l4 + 4) x_err = 1;
                            else begin
                                x_sp = {fb[l4], fb[l4+1]}; x_dp = {fb[l4+2], fb[l4+3]};
                            end
                        end
                    end
                end
            end
        end
        if (flen > MAXF) x_err = 1;
    endtask

    task automatic send(input bit gaps, input string etag);
        ref_model();
        for (int i = 0; i < flen; i++) begin
            if (gaps && i > 0 && ($urandom % 4) == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_last = 1'b0;
                chk("R2 busy held across idle gap", 64'(busy), 64'd1);
            end
            @(negedge clk);
            if (i == 0) chk("R2 busy low before frame", 64'(busy), 64'd0);
            else        chk("R2 busy mid-frame", 64'(busy), 64'd1);
            in_valid = 1'b1; in_data = fb[i]; in_last = (i == flen - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R2 done pulse", 64'(done), 64'd1);
        chk("R2 busy low at done", 64'(busy), 64'd0);
        chk(etag, 64'(hdr_error), 64'(x_err));
        if (!x_err) begin
            chk("R3 dst_mac", 64'(dst_mac), 64'(x_dmac));
            chk("R3 src_mac", 64'(src_mac), 64'(x_smac));
            chk("R4 vlan_tagged", 64'(vlan_tagged), 64'(x_vl));
            chk("R4 eth_type", 64'(eth_type), 64'(x_et));
            chk("R5 frame_class", 64'(frame_class), 64'(x_cls));
            chk("R6 ip_proto", 64'(ip_proto), 64'(x_pr));
            chk("R6 ip_src", 64'(ip_src), 64'(x_si));
            chk("R6 ip_dst", 64'(ip_dst), 64'(x_di));
            chk("R8 src port (R7 offset)", 64'(l4_src_port), 64'(x_sp));
            chk("R8 dst port (R7 offset)", 64'(l4_dst_port), 64'(x_dp));
            chk("R9 tcp_flags", 64'(tcp_flags), 64'(x_fl));
        end
        @(negedge clk);
        chk("R2 done single cycle", 64'(done), 64'd0);
        chk("R13 error held", 64'(hdr_error), 64'(x_err));
        if (!x_err) begin
            chk("R13 dst_mac held", 64'(dst_mac), 64'(x_dmac));
            chk("R13 ports held", 64'({l4_src_port, l4_dst_port}), 64'({x_sp, x_dp}));
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 error", 64'(hdr_error), 64'd0);
        chk("R1 class", 64'(frame_class), 64'd0);
        chk("R1 macs", 64'(dst_mac | src_mac), 64'd0);
        chk("R1 ip", 64'({ip_src, ip_dst}), 64'd0);
        chk("R1 l4", 64'({l4_src_port, l4_dst_port, tcp_flags, ip_proto, eth_type}), 64'd0);

        // directed classes
        build(1, 0, 5, 0);  send(0, "R10 error ARP");
        build(2, 0, 5, 6);  send(0, "R10 error TCP");
        build(3, 1, 7, 3);  send(1, "R10 error tagged UDP with options R7");
        build(4, 0, 5, 0);  send(0, "R10 error ICMP");
        build(5, 1, 5, 2);  send(0, "R10 error other protocol");
        build(0, 0, 5, 10); send(1, "R10 error other ethertype");
        build(2, 1, 8, 0);  send(0, "R10 error tagged TCP IHL 8 R7");

        // truncation thresholds
        build(2, 0, 5, 0); flen = 1;  send(0, "R10 one-byte frame");
        build(2, 0, 5, 0); flen = 13; send(0, "R10 13-byte frame");
        build(1, 1, 5, 0); flen = 17; send(0, "R10 tagged 17-byte stub");
        build(0, 1, 5, 0); flen = 18; send(0, "R10 tagged 18-byte other ok");
        build(2, 0, 5, 0); flen = 48; send(0, "R10 TCP exact length ok");
        build(2, 0, 5, 0); flen = 47; send(0, "R10 TCP one short");
        build(3, 0, 6, 0); flen = 42; send(0, "R10 UDP IHL6 exact ok");
        build(3, 0, 6, 0); flen = 41; send(0, "R10 UDP IHL6 one short");
        build(4, 1, 5, 0); flen = 37; send(0, "R10 ICMP header one short");

        // bad IHL
        build(3, 0, 4, 4); send(0, "R11 IHL 4 flagged");
        build(2, 1, 3, 4); send(0, "R11 IHL 3 flagged");

        // length limit
        build(3, 1, 5, 1476); send(0, "R12 1522 bytes accepted");
        build(3, 1, 5, 1477); send(0, "R12 1523 bytes flagged");
        build(1, 0, 5, 1480); send(0, "R12 1522 bytes untagged ARP accepted");

        // random mix
        for (int k = 0; k < 250; k++) begin
            int kind, ihl, pay;
            bit vl;
            kind = int'($urandom % 6);
            vl   = 1'($urandom);
            ihl  = (($urandom % 10) == 0) ? 3 + int'($urandom % 2) : 5 + int'($urandom % 4);
            pay  = int'($urandom % 31);
            build(kind, vl, ihl, pay);
            if (($urandom % 6) == 0 && flen > 1) flen = 1 + int'($urandom % (flen - 1));
            send(1'($urandom), "R10 R11 random error flag");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule